// File: doc/BRIEF.md
# Out-of-Band Flow Control Receiver

This block receives a slow serial flow control stream from a link partner. The stream has three wires: a forwarded clock, a data line and a sync line. All three are brought into a faster local system clock through multi-flop synchronizers. One bit is taken on each detected rising edge of the forwarded clock. The sync line marks the first bit of every frame, which sets the frame alignment.

Each frame carries two protected blocks. The first is a calendar block holding a 16-bit calendar. The second is a status block holding a link status bit and one status bit per lane. Each block ends with its own 4-bit CRC. A block that passes its CRC updates its outputs and raises a one-cycle "good" strobe in the system clock domain. A block that fails raises a one-cycle "bad" strobe and leaves the outputs holding their last good values. The status block can be left out at elaboration, in which case frames carry only the calendar block.

The system clock must run at least twice as fast as the forwarded clock. The block has one asynchronous reset in the system clock domain.

Top module: `oob_fc_rx`

## Requirements
- R1: While `sys_arst` is high, every output is 0. This takes effect at once, without waiting for a clock edge.
- R2: One bit is taken per rising edge of `fc_clk_in`, with `fc_data_in` and `fc_sync_in` sampled from the same edge. A bit with sync high is frame bit 0.
- R3: Frame layout with the status block present, for a total of CAL_W+LANES+9 bits (33 with the defaults):
  - bits 0..15 are the calendar, most significant bit first;
  - bits 16..19 are that block's CRC, most significant bit first;
  - bit 20 is the link status;
  - the next LANES bits are the lane status, lane LANES-1 first and lane 0 last;
  - the last 4 bits are the status block's CRC, most significant bit first.
- R4: Each block's CRC uses the polynomial x^4+x+1, is seeded to 4'b1111 at the block's first data bit, and covers the data bits only. For each data bit d, with fb = c[3]^d, the next CRC value is {c[2], c[1], c[0]^fb, fb}.
- R5: A calendar block whose received CRC equals the computed one pulses `cal_good` for one cycle. `cal_value` takes the new calendar in the same cycle.
- R6: A calendar block with a CRC mismatch pulses `cal_bad` for one cycle, and `cal_value` keeps its previous value.
- R7: A status block that passes its CRC pulses `stat_good` for one cycle. `lane_state` and `link_state` take the new values in the same cycle.
- R8: A status block that fails its CRC pulses `stat_bad` for one cycle, and `lane_state` and `link_state` keep their previous values.
- R9: The good and bad strobes of a block are never high together, and each lasts exactly one cycle.
- R10: Bits are ignored, and no strobe results, in two cases:
  - bits that arrive after reset and before the first sync;
  - bits that arrive after the last bit of a frame and before the next sync.
- R11: A sync-marked bit always starts a new frame. Any block that is only partly received is abandoned without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, at least twice the forwarded clock rate |
| sys_arst | input | 1 | Asynchronous reset, active high |
| fc_clk_in | input | 1 | Forwarded clock from the link partner |
| fc_data_in | input | 1 | Serial flow control data |
| fc_sync_in | input | 1 | Frame start marker |
| cal_value | output | CAL_W | Last calendar that passed its CRC |
| cal_good | output | 1 | One-cycle strobe: a new calendar passed its CRC |
| cal_bad | output | 1 | One-cycle strobe: a calendar block failed its CRC |
| lane_state | output | LANES | Last per-lane status that passed its CRC |
| link_state | output | 1 | Last link status that passed its CRC |
| stat_good | output | 1 | One-cycle strobe: new status passed its CRC |
| stat_bad | output | 1 | One-cycle strobe: a status block failed its CRC |

## Verification
A block can reach its last CRC bit on the same forwarded clock edge that carries a sync. The realignment and the block completion then compete in one cycle. The bench provokes this by cutting a frame one bit short, so that the next frame's sync lands where the status block's final CRC bit was due. The bench counts this as correct when neither status strobe fires for the abandoned block, the calendar of the cut frame is still delivered, and the following full frame delivers both of its blocks.

// File: rtl/oob_fc_rx_pkg.sv
`timescale 1ns/1ps
package oob_fc_rx_pkg;
   localparam int CRC_W = 4;
   localparam logic [CRC_W-1:0] CRC_SEED = 4'b1111;

   // One serial step of the x^4+x+1 CRC.
   function automatic logic [CRC_W-1:0] crc4_next(input logic [CRC_W-1:0] c, input logic d);
      logic fb;
      fb = c[3] ^ d;
      return {c[2], c[1], c[0] ^ fb, fb};
   endfunction
endpackage

// File: rtl/oob_fc_rx_sync.sv
`timescale 1ns/1ps
module oob_fc_rx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("oob_fc_rx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
         st_q[0] <= d;
         for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
   end

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/oob_fc_rx_align.sv
`timescale 1ns/1ps
module oob_fc_rx_align #(
   parameter int FRAME_LEN = 33,
   localparam int IDX_W    = $clog2(FRAME_LEN + 1)
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             fclk_s,
   input  logic             sync_s,
   output logic             take,
   output logic [IDX_W-1:0] idx
);
   logic             fclk_d;
   logic             aligned_q;
   logic [IDX_W-1:0] cnt_q;
   logic             edge_seen;
   logic [IDX_W-1:0] nxt;
   logic             cur_ok;

   assign edge_seen = fclk_s & ~fclk_d;
   assign nxt       = cnt_q + 1'b1;
   assign cur_ok    = sync_s | (aligned_q & (nxt < IDX_W'(FRAME_LEN)));
   assign idx       = sync_s ? '0 : nxt;
   assign take      = edge_seen & cur_ok;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         fclk_d    <= 1'b0;
         aligned_q <= 1'b0;
         cnt_q     <= '0;
      end else begin
         fclk_d <= fclk_s;
         if (edge_seen) begin
            aligned_q <= cur_ok;
            if (cur_ok) cnt_q <= idx;
         end
      end
   end

   // R10: the frame position never runs past the frame
   p_idx_range_r10: assert property (@(posedge clk) disable iff (arst)
      aligned_q |-> (cnt_q < IDX_W'(FRAME_LEN)));
   // R11: a sync-marked edge always restarts at bit 0
   p_sync_restart_r11: assert property (@(posedge clk) disable iff (arst)
      (edge_seen && sync_s) |=> (aligned_q && cnt_q == '0));
endmodule

// File: rtl/oob_fc_rx_block.sv
`timescale 1ns/1ps
module oob_fc_rx_block
   import oob_fc_rx_pkg::*;
#(
   parameter int DW    = 16,
   parameter int BASE  = 0,
   parameter int IDX_W = 6,
   localparam int BLK_LEN = DW + CRC_W
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             take,
   input  logic [IDX_W-1:0] idx,
   input  logic             bit_in,
   output logic             done,
   output logic             ok,
   output logic [DW-1:0]    word
);
   logic [IDX_W-1:0] pos;
   logic             in_blk;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-2:0] rxc_q;
   logic [DW-1:0]    data_q;
   logic [DW:0]      data_ext;
   logic             done_q, ok_q;

   assign pos      = idx - IDX_W'(BASE);
   assign in_blk   = take & (pos < IDX_W'(BLK_LEN));
   assign data_ext = {data_q, bit_in};

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         crc_q  <= CRC_SEED;
         rxc_q  <= '0;
         data_q <= '0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (in_blk) begin
            if (pos == '0) begin
               crc_q  <= crc4_next(CRC_SEED, bit_in);
               data_q <= data_ext[DW-1:0];
            end else if (pos < IDX_W'(DW)) begin
               crc_q  <= crc4_next(crc_q, bit_in);
               data_q <= data_ext[DW-1:0];
            end else if (pos == IDX_W'(BLK_LEN - 1)) begin
               done_q <= 1'b1;
               ok_q   <= ({rxc_q, bit_in} == crc_q);
            end else begin
               rxc_q <= {rxc_q[CRC_W-3:0], bit_in};
            end
         end
      end
   end

   assign done = done_q;
   assign ok   = ok_q;
   assign word = data_q;

   // R9: a completion needs a taken bit and lasts one cycle
   p_done_after_bit_r9: assert property (@(posedge clk) disable iff (arst)
      done_q |-> $past(take));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (arst)
      done_q |=> !done_q);
endmodule

// File: rtl/oob_fc_rx.sv
`timescale 1ns/1ps
module oob_fc_rx
   import oob_fc_rx_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int CAL_W       = 16,
   parameter bit STATUS_EN   = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             sys_clk,
   input  logic             sys_arst,
   input  logic             fc_clk_in,
   input  logic             fc_data_in,
   input  logic             fc_sync_in,
   output logic [CAL_W-1:0] cal_value,
   output logic             cal_good,
   output logic             cal_bad,
   output logic [LANES-1:0] lane_state,
   output logic             link_state,
   output logic             stat_good,
   output logic             stat_bad
);
   localparam int ST_W      = LANES + 1;
   localparam int CAL_BLK   = CAL_W + CRC_W;
   localparam int ST_BLK    = STATUS_EN ? (ST_W + CRC_W) : 0;
   localparam int FRAME_LEN = CAL_BLK + ST_BLK;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("oob_fc_rx: LANES must be at least 1");
   end
   if (CAL_W < 2) begin : g_bad_cal
      $error("oob_fc_rx: CAL_W must be at least 2");
   end

   logic [2:0]       sync_q;
   logic             take;
   logic [IDX_W-1:0] idx;
   logic             cal_done, cal_ok;
   logic [CAL_W-1:0] cal_word;

   oob_fc_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(sys_clk), .arst(sys_arst),
      .d({fc_clk_in, fc_sync_in, fc_data_in}), .q(sync_q));

   oob_fc_rx_align #(.FRAME_LEN(FRAME_LEN)) u_align (
      .clk(sys_clk), .arst(sys_arst), .fclk_s(sync_q[2]), .sync_s(sync_q[1]),
      .take(take), .idx(idx));

   oob_fc_rx_block #(.DW(CAL_W), .BASE(0), .IDX_W(IDX_W)) u_cal (
      .clk(sys_clk), .arst(sys_arst), .take(take), .idx(idx), .bit_in(sync_q[0]),
      .done(cal_done), .ok(cal_ok), .word(cal_word));

   always_ff @(posedge sys_clk or posedge sys_arst) begin
      if (sys_arst) begin
         cal_value <= '0;
         cal_good  <= 1'b0;
         cal_bad   <= 1'b0;
      end else begin
         cal_good <= cal_done & cal_ok;
         cal_bad  <= cal_done & ~cal_ok;
         if (cal_done & cal_ok) cal_value <= cal_word;
      end
   end

   if (STATUS_EN) begin : g_status
      logic            st_done, st_ok;
      logic [ST_W-1:0] st_word;

      oob_fc_rx_block #(.DW(ST_W), .BASE(CAL_BLK), .IDX_W(IDX_W)) u_stat (
         .clk(sys_clk), .arst(sys_arst), .take(take), .idx(idx), .bit_in(sync_q[0]),
         .done(st_done), .ok(st_ok), .word(st_word));

      always_ff @(posedge sys_clk or posedge sys_arst) begin
         if (sys_arst) begin
            lane_state <= '0;
            link_state <= 1'b0;
            stat_good  <= 1'b0;
            stat_bad   <= 1'b0;
         end else begin
            stat_good <= st_done & st_ok;
            stat_bad  <= st_done & ~st_ok;
            if (st_done & st_ok) begin
               link_state <= st_word[ST_W-1];
               lane_state <= st_word[LANES-1:0];
            end
         end
      end

      // R8: status holds unless a good strobe accompanies the change
      p_stat_hold_r8: assert property (@(posedge sys_clk) disable iff (sys_arst)
         ({link_state, lane_state} != $past({link_state, lane_state})) |-> stat_good);
      // R9: status strobes exclusive and single-cycle
      p_stat_excl_r9: assert property (@(posedge sys_clk) disable iff (sys_arst)
         !(stat_good && stat_bad));
      p_stat_pulse_r9: assert property (@(posedge sys_clk) disable iff (sys_arst)
         (stat_good || stat_bad) |=> !(stat_good || stat_bad));
   end else begin : g_no_status
      assign lane_state = '0;
      assign link_state = 1'b0;
      assign stat_good  = 1'b0;
      assign stat_bad   = 1'b0;
   end

   // R1: outputs cleared while reset is held
   p_rst_clear_r1: assert property (@(posedge sys_clk)
      sys_arst |-> (cal_value == '0 && !cal_good && !cal_bad && !stat_good && !stat_bad));
   // R6: calendar changes only together with a good strobe
   p_cal_hold_r6: assert property (@(posedge sys_clk) disable iff (sys_arst)
      (cal_value != $past(cal_value)) |-> cal_good);
   // R9: calendar strobes exclusive and single-cycle
   p_cal_excl_r9: assert property (@(posedge sys_clk) disable iff (sys_arst)
      !(cal_good && cal_bad));
   p_cal_pulse_r9: assert property (@(posedge sys_clk) disable iff (sys_arst)
      (cal_good || cal_bad) |=> !(cal_good || cal_bad));
endmodule

// File: tb/oob_fc_rx_test.sv
`timescale 1ns/1ps
module oob_fc_rx_test;
   localparam int LANES = 8;
   localparam int CAL_W = 16;
   localparam int ST_W  = LANES + 1;
   localparam int FLEN  = CAL_W + 4 + ST_W + 4;

   logic clk = 1'b0, rst = 1'b1, fck = 1'b0, fd = 1'b0, fs = 1'b0;
   logic [CAL_W-1:0] cal_value;
   logic [LANES-1:0] lane_state;
   logic cal_good, cal_bad, link_state, stat_good, stat_bad;

   always #5 clk = ~clk;

   oob_fc_rx #(.LANES(LANES), .CAL_W(CAL_W), .STATUS_EN(1'b1), .SYNC_STAGES(2)) uut (
      .sys_clk(clk), .sys_arst(rst), .fc_clk_in(fck), .fc_data_in(fd), .fc_sync_in(fs),
      .cal_value(cal_value), .cal_good(cal_good), .cal_bad(cal_bad),
      .lane_state(lane_state), .link_state(link_state),
      .stat_good(stat_good), .stat_bad(stat_bad));

   int n_cg = 0, n_cb = 0, n_sg = 0, n_sb = 0;
   int total = 0, fails = 0;
   logic fbits [FLEN];
   logic [CAL_W-1:0] exp_cal = '0;
   logic [ST_W-1:0]  exp_st  = '0;

   always @(negedge clk) if (!rst) begin
      if (cal_good)  n_cg++;
      if (cal_bad)   n_cb++;
      if (stat_good) n_sg++;
      if (stat_bad)  n_sb++;
   end

   function automatic logic [3:0] ref_crc(input logic [31:0] v, input int n);
      logic [3:0] c = 4'b1111;
      for (int i = n - 1; i >= 0; i--) begin
         logic fb = c[3] ^ v[i];
         c = {c[2], c[1], c[0] ^ fb, fb};
      end
      return c;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R3 layout, R4 CRC
   task automatic build(input logic [CAL_W-1:0] cal, input logic [ST_W-1:0] st,
                        input logic badc, input logic bads);
      logic [3:0] c1, c2;
      c1 = ref_crc(32'(cal), CAL_W) ^ {3'b000, badc};
      c2 = ref_crc(32'(st), ST_W) ^ {3'b000, bads};
      for (int i = 0; i < CAL_W; i++) fbits[i] = cal[CAL_W-1-i];
      for (int i = 0; i < 4; i++) fbits[CAL_W+i] = c1[3-i];
      for (int i = 0; i < ST_W; i++) fbits[CAL_W+4+i] = st[ST_W-1-i];
      for (int i = 0; i < 4; i++) fbits[CAL_W+4+ST_W+i] = c2[3-i];
   endtask

   task automatic send_bits(input int count, input logic with_sync);
      for (int i = 0; i < count; i++) begin
         fd = fbits[i];
         fs = with_sync && (i == 0);
         #20 fck = 1'b1;
         #20 fck = 1'b0;
      end
      fs = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(posedge clk);
      #2;
   endtask

   task automatic run_frame(input logic [CAL_W-1:0] cal, input logic [ST_W-1:0] st,
                            input logic badc, input logic bads);
      int cg0 = n_cg, cb0 = n_cb, sg0 = n_sg, sb0 = n_sb;
      build(cal, st, badc, bads);
      send_bits(FLEN, 1'b1);
      settle();
      if (!badc) exp_cal = cal;
      if (!bads) exp_st = st;
      check(badc ? "R6 cal_bad count" : "R5 cal_good count",
            badc ? n_cb - cb0 : n_cg - cg0, 1);
      check("R9 cal other strobe", badc ? n_cg - cg0 : n_cb - cb0, 0);
      check(badc ? "R6 cal held" : "R5 cal value", cal_value, exp_cal);
      check(bads ? "R8 stat_bad count" : "R7 stat_good count",
            bads ? n_sb - sb0 : n_sg - sg0, 1);
      check("R9 stat other strobe", bads ? n_sg - sg0 : n_sb - sb0, 0);
      check(bads ? "R8 status held" : "R7 status value",
            {link_state, lane_state}, exp_st);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

   initial begin
      int cg0, cb0, sg0, sb0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      check("R1 reset cal", cal_value, 0);
      check("R1 reset status", {link_state, lane_state}, 0);
      check("R1 reset strobes", {cal_good, cal_bad, stat_good, stat_bad}, 0);
      @(negedge clk) rst = 1'b0;

      // R10: bits before the first sync are ignored
      for (int i = 0; i < FLEN; i++) fbits[i] = 1'($urandom);
      send_bits(FLEN, 1'b0);
      settle();
      check("R10 no strobes before sync", n_cg + n_cb + n_sg + n_sb, 0);

      // R2 R3 R4 R5 R7: directed corner values
      run_frame(16'hFFFF, 9'h1FF, 1'b0, 1'b0);
      run_frame(16'h0000, 9'h000, 1'b0, 1'b0);
      run_frame(16'hA5C3, 9'h155, 1'b0, 1'b0);
      // R6: bad calendar, status good
      run_frame(16'h1234, 9'h0F0, 1'b1, 1'b0);
      // R8: bad status, calendar good
      run_frame(16'h8001, 9'h1AA, 1'b0, 1'b1);

      // R10: trailing bits after a full frame without sync are ignored
      cg0 = n_cg; cb0 = n_cb; sg0 = n_sg; sb0 = n_sb;
      build(16'h5A5A, 9'h033, 1'b0, 1'b0);
      send_bits(FLEN, 1'b1);
      build(16'h0F0F, 9'h101, 1'b0, 1'b0);
      send_bits(FLEN, 1'b0);
      settle();
      exp_cal = 16'h5A5A; exp_st = 9'h033;
      check("R10 trailing cal count", n_cg - cg0, 1);
      check("R10 trailing stat count", n_sg - sg0, 1);
      check("R10 trailing no bad", (n_cb - cb0) + (n_sb - sb0), 0);
      check("R10 trailing cal value", cal_value, exp_cal);

      // R11: sync lands where last status CRC bit was due
      cg0 = n_cg; cb0 = n_cb; sg0 = n_sg; sb0 = n_sb;
      build(16'hC0DE, 9'h0AA, 1'b0, 1'b0);
      send_bits(FLEN - 1, 1'b1);
      build(16'hBEEF, 9'h1C7, 1'b0, 1'b0);
      send_bits(FLEN, 1'b1);
      settle();
      exp_cal = 16'hBEEF; exp_st = 9'h1C7;
      check("R11 cal count both frames", n_cg - cg0, 2);
      check("R11 abandoned status no strobe", n_sg - sg0, 1);
      check("R11 no bad strobes", (n_cb - cb0) + (n_sb - sb0), 0);
      check("R11 status from new frame", {link_state, lane_state}, exp_st);
      check("R11 cal from new frame", cal_value, exp_cal);

      // R5 R6 R7 R8: random frames with random corruption
      for (int k = 0; k < 30; k++)
         run_frame(16'($urandom), 9'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);

      // R1: asynchronous reset mid-run
      #3 rst = 1'b1;
      #1;
      check("R1 async clear cal", cal_value, 0);
      check("R1 async clear status", {link_state, lane_state}, 0);
      @(negedge clk) rst = 1'b0;
      exp_cal = '0; exp_st = '0;
      run_frame(16'h7E81, 9'h0C3, 1'b0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end
endmodule